// File: doc/BRIEF.md
# Rotated Tiled-View Address Generator

This block converts a pixel coordinate into an address inside a tiled memory aperture, taking into account the pixel format and the view orientation. Each request carries a valid bit, a 2-bit format, a 3-bit orientation code and an (x, y) coordinate. The orientation code can invert the X axis, invert the Y axis and swap the two axes in the coordinate interleave. The interleaved offset is then scaled by the format's bytes-per-pixel shift. The format and the orientation are written into the top bits of the address, so the memory side can decode which view is being accessed.

For each request the block also gives the line stride of the chosen view. That is the address step between two vertically adjacent pixels as the view sees them. A coordinate outside the format's addressable range gives address zero and raises an error flag. The block is a two-stage pipeline. It accepts one request per cycle and returns each result two clock edges after it was taken. Translation of the aperture address to physical memory happens downstream and is not part of this block.

Top module: `tiler_view_agen`

## Requirements
- R1: For an in-range result, address bits [28:27] carry the request's format code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = page mode.
- R2: For an in-range result, address bits [31:29] carry the request's 3-bit orientation code unchanged.
- R3: Per format, X has (CW_BITS − xs) bits and Y has (CH_BITS − ys) bits. The unused-bit pairs (xs, ys) are (0,0) for 8-bit, (0,1) for 16-bit, (1,1) for 32-bit and (SW_BITS, SH_BITS) for page mode. If x or y is above its all-ones mask, the whole address is 0 and the error flag is 1. Otherwise the error flag is 0.
- R4: Orientation bit 1 XORs x with its mask and orientation bit 0 XORs y with its mask. This happens before interleaving.
- R5: Orientation bit 2 clear gives an offset of (y << xbits) + x. Orientation bit 2 set gives (x << ybits) + y. The offset is shifted left by xs + ys and placed in address bits [26:0].
- R6: The stride is 1 << (CH_BITS + xs) when orientation bit 2 is set, and 1 << (CW_BITS + ys) otherwise. It is given for every result, whether in range or not.
- R7: One request is accepted every cycle. A request sampled at clock edge k appears on the outputs after edge k+1, with the output valid asserted for exactly that cycle.
- R8: While reset is held, the output valid, address, stride and error flag are all zero.
- R9: When no result is being delivered, the address, stride and error flag keep their previous values, whatever is presented on the request inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_fmt | input | 2 | Pixel format code |
| in_orient | input | 3 | View orientation code (bit 2 swap, bit 1 X invert, bit 0 Y invert) |
| in_x | input | COORD_W | Pixel X coordinate |
| in_y | input | COORD_W | Pixel Y coordinate |
| out_valid | output | 1 | Result valid |
| out_addr | output | 32 | Tiled-aperture address |
| out_stride | output | 32 | Line stride of the view |
| out_err | output | 1 | Coordinate out of range |

## Verification
The bench builds the block with its default values: 14 container-width bits, 13 container-height bits, a 6 × 5 bit page slot and 16-bit coordinate inputs. Because the inputs are wider than any mask, every format can be pushed past its range on either axis. The page format's small masks (8 bits on each axis) make that overflow common even under random stimulus. Directed passes go to both edges of each mask under all eight orientation codes. They also insert bubbles with changing inputs, to show that the outputs hold while no result is delivered.

// File: rtl/tiler_view_pkg.sv
package tiler_view_pkg;

    localparam int FMT_N = 4;

    typedef enum logic [1:0] {
        TV_FMT_8    = 2'd0,
        TV_FMT_16   = 2'd1,
        TV_FMT_32   = 2'd2,
        TV_FMT_PAGE = 2'd3
    } tv_fmt_e;

    typedef struct packed {
        logic swap;
        logic xinv;
        logic yinv;
    } tv_orient_t;

    // unused X coordinate bits for a format
    function automatic int fmt_xshift(input int f, input int slot_w_bits);
        case (f)
            0, 1:    return 0;
            2:       return 1;
            default: return slot_w_bits;
        endcase
    endfunction

    // unused Y coordinate bits for a format
    function automatic int fmt_yshift(input int f, input int slot_h_bits);
        case (f)
            0:       return 0;
            1, 2:    return 1;
            default: return slot_h_bits;
        endcase
    endfunction

endpackage

// File: rtl/tva_coord_stage.sv
module tva_coord_stage
    import tiler_view_pkg::*;
#(
    parameter int CW_BITS = 14,
    parameter int CH_BITS = 13,
    parameter int SW_BITS = 6,
    parameter int SH_BITS = 5,
    parameter int COORD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         in_fmt,
    input  logic [2:0]         in_orient,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    output logic               s1_valid,
    output logic [1:0]         s1_fmt,
    output tv_orient_t         s1_orient,
    output logic [CW_BITS-1:0] s1_x,
    output logic [CH_BITS-1:0] s1_y,
    output logic               s1_err
);

    logic [CW_BITS-1:0] xmask_f [FMT_N];
    logic [CH_BITS-1:0] ymask_f [FMT_N];

    for (genvar f = 0; f < FMT_N; f++) begin : g_mask
        localparam int XS = fmt_xshift(f, SW_BITS);
        localparam int YS = fmt_yshift(f, SH_BITS);
        assign xmask_f[f] = {CW_BITS{1'b1}} >> XS;
        assign ymask_f[f] = {CH_BITS{1'b1}} >> YS;
    end

    tv_orient_t         orient_in;
    logic [CW_BITS-1:0] xm;
    logic [CH_BITS-1:0] ym;
    logic               range_bad;
    logic [CW_BITS-1:0] x_adj;
    logic [CH_BITS-1:0] y_adj;

    always_comb begin
        orient_in = tv_orient_t'(in_orient);
        xm        = xmask_f[in_fmt];
        ym        = ymask_f[in_fmt];
        range_bad = (32'(in_x) > 32'(xm)) || (32'(in_y) > 32'(ym));
        x_adj     = in_x[CW_BITS-1:0] ^ (orient_in.xinv ? xm : '0);
        y_adj     = in_y[CH_BITS-1:0] ^ (orient_in.yinv ? ym : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_fmt    <= '0;
            s1_orient <= '0;
            s1_x      <= '0;
            s1_y      <= '0;
            s1_err    <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_fmt    <= in_fmt;
                s1_orient <= orient_in;
                s1_x      <= x_adj;
                s1_y      <= y_adj;
                s1_err    <= range_bad;
            end
        end
    end

    // R3/R4: a staged in-range coordinate never exceeds its format mask
    p_staged_in_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_err) |-> ((s1_x <= xmask_f[s1_fmt]) && (s1_y <= ymask_f[s1_fmt])));

endmodule

// File: rtl/tva_compose_stage.sv
module tva_compose_stage
    import tiler_view_pkg::*;
#(
    parameter int CW_BITS = 14,
    parameter int CH_BITS = 13,
    parameter int SW_BITS = 6,
    parameter int SH_BITS = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s1_valid,
    input  logic [1:0]         s1_fmt,
    input  tv_orient_t         s1_orient,
    input  logic [CW_BITS-1:0] s1_x,
    input  logic [CH_BITS-1:0] s1_y,
    input  logic               s1_err,
    output logic               out_valid,
    output logic [31:0]        out_addr,
    output logic [31:0]        out_stride,
    output logic               out_err
);

    localparam int OFF_W = CW_BITS + CH_BITS;

    logic [OFF_W-1:0] off_f    [FMT_N];
    logic [31:0]      stride_f [FMT_N];

    for (genvar f = 0; f < FMT_N; f++) begin : g_fmt
        localparam int XS = fmt_xshift(f, SW_BITS);
        localparam int YS = fmt_yshift(f, SH_BITS);
        localparam int XB = CW_BITS - XS;
        localparam int YB = CH_BITS - YS;
        logic [OFF_W-1:0] row_major;
        logic [OFF_W-1:0] col_major;
        assign row_major   = OFF_W'({s1_y[YB-1:0], s1_x[XB-1:0]}) << (XS + YS);
        assign col_major   = OFF_W'({s1_x[XB-1:0], s1_y[YB-1:0]}) << (XS + YS);
        assign off_f[f]    = s1_orient.swap ? col_major : row_major;
        assign stride_f[f] = s1_orient.swap ? (32'd1 << (CH_BITS + XS))
                                            : (32'd1 << (CW_BITS + YS));
    end

    logic [31:0] addr_nxt;

    always_comb begin
        if (s1_err)
            addr_nxt = '0;
        else
            addr_nxt = 32'({s1_orient, s1_fmt, off_f[s1_fmt]});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_addr   <= '0;
            out_stride <= '0;
            out_err    <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_addr   <= addr_nxt;
                out_stride <= stride_f[s1_fmt];
                out_err    <= s1_err;
            end
        end
    end

    p_err_gives_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_addr == 32'd0));

    p_stride_power_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_stride) == 1));

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> ($stable(out_addr) && $stable(out_stride) && $stable(out_err)));

endmodule

// File: rtl/tiler_view_agen.sv
module tiler_view_agen
    import tiler_view_pkg::*;
#(
    parameter int CW_BITS = 14,
    parameter int CH_BITS = 13,
    parameter int SW_BITS = 6,
    parameter int SH_BITS = 5,
    parameter int COORD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         in_fmt,
    input  logic [2:0]         in_orient,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    output logic               out_valid,
    output logic [31:0]        out_addr,
    output logic [31:0]        out_stride,
    output logic               out_err
);

    logic               s1_valid;
    logic [1:0]         s1_fmt;
    tv_orient_t         s1_orient;
    logic [CW_BITS-1:0] s1_x;
    logic [CH_BITS-1:0] s1_y;
    logic               s1_err;

    tva_coord_stage #(
        .CW_BITS(CW_BITS), .CH_BITS(CH_BITS),
        .SW_BITS(SW_BITS), .SH_BITS(SH_BITS), .COORD_W(COORD_W)
    ) u_coord (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_fmt(in_fmt), .in_orient(in_orient),
        .in_x(in_x), .in_y(in_y),
        .s1_valid(s1_valid), .s1_fmt(s1_fmt), .s1_orient(s1_orient),
        .s1_x(s1_x), .s1_y(s1_y), .s1_err(s1_err)
    );

    tva_compose_stage #(
        .CW_BITS(CW_BITS), .CH_BITS(CH_BITS),
        .SW_BITS(SW_BITS), .SH_BITS(SH_BITS)
    ) u_compose (
        .clk(clk), .rst_n(rst_n),
        .s1_valid(s1_valid), .s1_fmt(s1_fmt), .s1_orient(s1_orient),
        .s1_x(s1_x), .s1_y(s1_y), .s1_err(s1_err),
        .out_valid(out_valid), .out_addr(out_addr),
        .out_stride(out_stride), .out_err(out_err)
    );

    p_two_cycle_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    p_format_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> (out_addr[28:27] == $past(in_fmt, 2)));

    p_view_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> (out_addr[31:29] == $past(in_orient, 2)));

endmodule

// File: tb/tiler_view_agen_tb.sv
module tiler_view_agen_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_fmt = '0;
    logic [2:0]  in_orient = '0;
    logic [15:0] in_x = '0;
    logic [15:0] in_y = '0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic [31:0] out_stride;
    logic        out_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tiler_view_agen u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
        .in_orient(in_orient), .in_x(in_x), .in_y(in_y),
        .out_valid(out_valid), .out_addr(out_addr),
        .out_stride(out_stride), .out_err(out_err)
    );

    typedef struct {
        bit v;
        int f;
        int o;
        int x;
        int y;
    } req_t;

    req_t p0 = '{0, 0, 0, 0, 0};
    req_t p1 = '{0, 0, 0, 0, 0};
    logic [31:0] m_addr   = '0;
    logic [31:0] m_stride = '0;
    logic        m_err    = 1'b0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int xsh(input int f);
        return (f == 2) ? 1 : (f == 3) ? 6 : 0;
    endfunction

    function automatic int ysh(input int f);
        return (f == 0) ? 0 : (f == 3) ? 5 : 1;
    endfunction

    function automatic longint xmax(input int f);
        return (longint'(1) << (14 - xsh(f))) - 1;
    endfunction

    function automatic longint ymax(input int f);
        return (longint'(1) << (13 - ysh(f))) - 1;
    endfunction

    // behavioural reference for one request
    task automatic model(input req_t r);
        longint xm, ym, xx, yy, off;
        int xs, ys;
        xs = xsh(r.f);
        ys = ysh(r.f);
        xm = xmax(r.f);
        ym = ymax(r.f);
        if (((r.o >> 2) & 1) == 1) m_stride = 32'(longint'(1) << (13 + xs));
        else                       m_stride = 32'(longint'(1) << (14 + ys));
        if (r.x > xm || r.y > ym) begin
            m_addr = '0;
            m_err  = 1'b1;
        end else begin
            xx = r.x;
            yy = r.y;
            if (((r.o >> 1) & 1) == 1) xx = xm - xx;
            if ((r.o & 1) == 1)        yy = ym - yy;
            if (((r.o >> 2) & 1) == 1) off = xx * (ym + 1) + yy;
            else                       off = yy * (xm + 1) + xx;
            off    = off * (longint'(1) << (xs + ys));
            m_addr = 32'(longint'(r.o) * 32'h2000_0000 + longint'(r.f) * 32'h0800_0000 + off);
            m_err  = 1'b0;
        end
    endtask

    task automatic step(input bit v, input int f, input int o, input int x, input int y);
        req_t nr;
        @(negedge clk);
        chk("R7 valid timing", longint'(out_valid), longint'(p1.v));
        if (p1.v) begin
            model(p1);
            chk("R3 error flag", longint'(out_err), longint'(m_err));
            if (m_err) begin
                chk("R3 zero address", longint'(out_addr), 0);
            end else begin
                chk("R1 format field", longint'(out_addr[28:27]), longint'(m_addr[28:27]));
                chk("R2 view field", longint'(out_addr[31:29]), longint'(m_addr[31:29]));
                if ((p1.o & 3) != 0)
                    chk("R4 inverted offset", longint'(out_addr[26:0]), longint'(m_addr[26:0]));
                else
                    chk("R5 offset", longint'(out_addr[26:0]), longint'(m_addr[26:0]));
            end
            chk("R6 stride", longint'(out_stride), longint'(m_stride));
        end else begin
            chk("R9 address hold", longint'(out_addr), longint'(m_addr));
            chk("R9 stride hold", longint'(out_stride), longint'(m_stride));
            chk("R9 error hold", longint'(out_err), longint'(m_err));
        end
        p1 = p0;
        nr = '{v, f, o, x, y};
        p0 = nr;
        in_valid  = v;
        in_fmt    = 2'(f);
        in_orient = 3'(o);
        in_x      = 16'(x);
        in_y      = 16'(y);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R8: reset state, with a request presented during reset
        in_valid = 1'b1;
        in_x     = 16'h1234;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset valid", longint'(out_valid), 0);
        chk("R8 reset addr", longint'(out_addr), 0);
        chk("R8 reset stride", longint'(out_stride), 0);
        chk("R8 reset err", longint'(out_err), 0);
        in_valid = 1'b0;
        rst_n    = 1'b1;

        // directed corners: every format and view, mask edges and one past them
        for (int f = 0; f < 4; f++) begin
            for (int o = 0; o < 8; o++) begin
                step(1, f, o, int'(xmax(f)), 0);
                step(1, f, o, 0, int'(ymax(f)));
                step(1, f, o, int'(xmax(f)), int'(ymax(f)));
                step(1, f, o, int'(xmax(f)) + 1, 3);
                step(1, f, o, 5, int'(ymax(f)) + 1);
                step(1, f, o, int'(xmax(f)) / 3, int'(ymax(f)) / 5);
                // bubble with changing inputs (R9)
                step(0, 3 - f, 7 - o, 16'hffff, 16'h0);
                step(0, f, o, 1, 1);
            end
        end

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int f, o, x, y;
            f = int'($urandom % 4);
            o = int'($urandom % 8);
            if ($urandom % 8 == 0) begin
                x = int'($urandom % 65536);
                y = int'($urandom % 65536);
            end else begin
                x = int'($urandom % (xmax(f) + 1));
                y = int'($urandom % (ymax(f) + 1));
            end
            step(($urandom % 4) != 0, f, o, x, y);
        end

        // drain
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule